// File: doc/BRIEF.md
# Banked Multi-Channel DMA Control Register File

This block is the control and status register file of a multi-channel DMA engine. Software reaches it over a simple 32-bit register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. The engine's data path is not part of this block. The block gives the engine each channel's configuration. It also takes per-channel, per-cause event pulses from the engine and turns them into one combined interrupt.

Only one channel's private registers are visible at a time. Software first writes a channel index into a select register. Later accesses to the shared window then reach that channel's control word, descriptor base, descriptor count, interrupt status and interrupt enable. Port control registers are reached the same way, through a separate port index. Two reset actions clear themselves: a per-channel reset and an engine-wide reset. Each one reads back as busy until it has finished. A global vector holds one interrupt enable per channel. A read-only identity word reports the hardware revision and the number of ports and channels.

Top module: `dmac_reg_bank`

## Requirements
- R1: Reading offset 0x08 returns the identity word: the channel count in bits 31:20, the port count in bits 19:16, the revision in bits 4:0, and zero in all other bits. Writes to this offset change nothing.
- R2: The channel index written at 0x18 reads back at 0x18. It selects which channel's registers are reached at 0x1C (control), 0x20 (descriptor base, 32 bits), 0x24 (descriptor count, low CNT_W bits) and 0x28/0x2C. Each channel keeps its own copy of these registers.
- R3: In the channel control word, bit 0 turns the channel on, bit 8 marks it as transmit, and bits 17:16 hold its weight. These fields read back as written and every other bit reads 0. Output chan_on_o bit n follows bit 0 of channel n.
- R4: Writing a 1 to control bit 1 starts a channel reset. Bit 1 reads 1 for the 4 cycles after the write and then reads 0. When the reset completes, it clears the channel-on bit and all of that channel's status bits.
- R5: Status bits 6:1 are set by a one-cycle pulse on evt_i bit (n*6+k), which sets bit k+1 of channel n (bit 3 is descriptor-complete). Writing to 0x28 clears only the bits written as 1, so 0x7E clears all of them. An event arriving in the same cycle as a clear wins.
- R6: The interrupt enable at 0x2C stores bits 6:1. irq_o is high when some channel has a status bit set whose enable is also set, and that channel's global enable bit is also set.
- R7: The global enable at 0xF4 has bit n for channel n and reads back as written. Writing 0 to it forces irq_o low.
- R8: Writing a 1 to bit 0 at 0x10 starts an engine reset. Bit 0 and engine_rst_o stay high for the 4 cycles after the write and then go low.
- R9: The polling register at 0x14 stores only bit 31 (polling on) and bit 6 (divide-by-4 polling clock). All other bits read 0.
- R10: The port index written at 0x40 reads back at 0x40. It selects which port's control register is reached at 0x44. Each port stores the low PCTRL_W bits of that register.
- R11: If the channel index is not below NUM_CH, or the port index is not below NUM_PORT, the banked window reads 0 and ignores writes.
- R12: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| evt_i | input | NUM_CH*6 | Event pulses, channel n cause k at bit n*6+k |
| chan_on_o | output | NUM_CH | Channel-on bits |
| engine_rst_o | output | 1 | Engine reset in progress |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes and event pulses take effect at the clock edge that samples them. Because of that, chan_on_o, irq_o and engine_rst_o are checked at the falling edge right after that edge. A read result is due one edge after its strobe. The driver queues the expected word when it raises the strobe, and the monitor compares it at the next falling edge. The two self-clearing resets are read back-to-back right after their start. This shows the busy bit for exactly four reads before it drops on the fifth.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int ADDR_W   = 8;
    localparam int STAT_W   = 6;
    localparam int STAT_LSB = 1;

    localparam logic [ADDR_W-1:0] OFF_ID    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_GCTRL = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_POLL  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_CHSEL = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_CCTRL = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_DBASE = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_DCNT  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_PSEL  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_PCTRL = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_GIEN  = 8'hF4;

    localparam int CC_ON     = 0;
    localparam int CC_RST    = 1;
    localparam int CC_TX     = 8;
    localparam int CC_WT     = 16;
    localparam int POLL_DIV4 = 6;
    localparam int POLL_EN   = 31;

    typedef enum logic [2:0] {
        WIN_NONE, WIN_CTRL, WIN_BASE, WIN_CNT, WIN_STAT, WIN_IEN
    } win_e;

    function automatic win_e decode_win(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CCTRL: return WIN_CTRL;
            OFF_DBASE: return WIN_BASE;
            OFF_DCNT:  return WIN_CNT;
            OFF_ISTAT: return WIN_STAT;
            OFF_IEN:   return WIN_IEN;
            default:   return WIN_NONE;
        endcase
    endfunction
endpackage

// File: rtl/dmac_selfclr_timer.sv
module dmac_selfclr_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (start_i)
            t_d.cnt = CW'(CYCLES);
        else if (t_q.cnt != '0)
            t_d.cnt = t_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = (t_q.cnt != '0);
    assign done_o = (t_q.cnt == CW'(1)) && !start_i;

    // checker: cycles spent busy since the last start
    logic [CW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  age_q <= '0;
        else if (start_i || !busy_o) age_q <= '0;
        else                         age_q <= age_q + 1'b1;
    end

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (age_q < CW'(CYCLES)));
endmodule

// File: rtl/dmac_chan_slot.sv
module dmac_chan_slot
    import dmac_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  win_e              win_i,
    input  logic [31:0]       wdata_i,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              gen_en_i,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       base_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [STAT_W-1:0] stat_o,
    output logic [STAT_W-1:0] ien_o,
    output logic              irq_o,
    output logic              on_o,
    output logic              busy_o
);
    typedef struct packed {
        logic              on;
        logic              tx;
        logic [1:0]        wt;
        logic [31:0]       base;
        logic [CNT_W-1:0]  cnt;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] ien;
    } slot_t;

    slot_t s_q, s_d;
    logic [STAT_W-1:0] clr;
    logic start, done;

    assign start = wr_i && (win_i == WIN_CTRL) && wdata_i[CC_RST];

    dmac_selfclr_timer #(.CYCLES(RST_CYCLES)) u_rst_tmr (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_o), .done_o(done)
    );

    always_comb begin
        s_d = s_q;
        clr = '0;
        if (wr_i) begin
            case (win_i)
                WIN_CTRL: begin
                    s_d.on = wdata_i[CC_ON];
                    s_d.tx = wdata_i[CC_TX];
                    s_d.wt = wdata_i[CC_WT +: 2];
                end
                WIN_BASE: s_d.base = wdata_i;
                WIN_CNT:  s_d.cnt  = wdata_i[CNT_W-1:0];
                WIN_STAT: clr      = wdata_i[STAT_LSB +: STAT_W];
                WIN_IEN:  s_d.ien  = wdata_i[STAT_LSB +: STAT_W];
                default: ;
            endcase
        end
        s_d.stat = (s_q.stat & ~clr) | evt_i;
        if (done) begin
            s_d.on   = 1'b0;
            s_d.stat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = {14'b0, s_q.wt, 7'b0, s_q.tx, 6'b0, busy_o, s_q.on};
    assign base_o = s_q.base;
    assign cnt_o  = s_q.cnt;
    assign stat_o = s_q.stat;
    assign ien_o  = s_q.ien;
    assign on_o   = s_q.on;
    assign irq_o  = gen_en_i && |(s_q.stat & s_q.ien);

    assert_w1c_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_i && win_i == WIN_STAT) && !done) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
    assert_rst_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (stat_o == '0 && !on_o));
endmodule

// File: rtl/dmac_reg_bank.sv
module dmac_reg_bank
    import dmac_pkg::*;
#(
    parameter int         NUM_CH     = 20,
    parameter int         NUM_PORT   = 4,
    parameter logic [4:0] HW_REV     = 5'h0A,
    parameter int         CNT_W      = 16,
    parameter int         SEL_W      = 8,
    parameter int         PCTRL_W    = 12,
    parameter int         RST_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_CH*STAT_W-1:0] evt_i,
    output logic [NUM_CH-1:0]        chan_on_o,
    output logic                     engine_rst_o,
    output logic                     irq_o
);
    localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int PT_IW = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]                     sel_ch;
        logic [SEL_W-1:0]                     sel_port;
        logic                                 poll_en;
        logic                                 poll_div4;
        logic [NUM_CH-1:0]                    gien;
        logic [NUM_PORT-1:0][PCTRL_W-1:0]     pctrl;
        logic [31:0]                          rdata;
    } bank_t;

    bank_t s_q, s_d;

    win_e                          win;
    logic                          ch_ok, pt_ok;
    logic [CH_IW-1:0]              ch_idx;
    logic [PT_IW-1:0]              pt_idx;
    logic [NUM_CH-1:0]             slot_wr, slot_irq, rst_busy;
    logic [NUM_CH-1:0][31:0]       s_ctrl, s_base;
    logic [NUM_CH-1:0][CNT_W-1:0]  s_cnt;
    logic [NUM_CH-1:0][STAT_W-1:0] s_stat, s_ien;
    logic [31:0]                   rd_word;
    logic                          eng_start, eng_busy, eng_done;

    assign win    = decode_win(bus_addr);
    assign ch_ok  = s_q.sel_ch < SEL_W'(NUM_CH);
    assign pt_ok  = s_q.sel_port < SEL_W'(NUM_PORT);
    assign ch_idx = s_q.sel_ch[CH_IW-1:0];
    assign pt_idx = s_q.sel_port[PT_IW-1:0];

    always_comb begin
        slot_wr = '0;
        if (bus_wr && ch_ok && win != WIN_NONE)
            slot_wr[ch_idx] = 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        dmac_chan_slot #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_i(slot_wr[c]), .win_i(win), .wdata_i(bus_wdata),
            .evt_i(evt_i[c*STAT_W +: STAT_W]), .gen_en_i(s_q.gien[c]),
            .ctrl_o(s_ctrl[c]), .base_o(s_base[c]), .cnt_o(s_cnt[c]),
            .stat_o(s_stat[c]), .ien_o(s_ien[c]), .irq_o(slot_irq[c]),
            .on_o(chan_on_o[c]), .busy_o(rst_busy[c])
        );
    end

    assign eng_start = bus_wr && (bus_addr == OFF_GCTRL) && bus_wdata[0];

    dmac_selfclr_timer #(.CYCLES(RST_CYCLES)) u_eng_tmr (
        .clk(clk), .rst_n(rst_n), .start_i(eng_start), .busy_o(eng_busy), .done_o(eng_done)
    );

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            OFF_ID:    rd_word = {12'(NUM_CH), 4'(NUM_PORT), 11'b0, HW_REV};
            OFF_GCTRL: rd_word = {31'b0, eng_busy};
            OFF_POLL:  rd_word = {s_q.poll_en, 24'b0, s_q.poll_div4, 6'b0};
            OFF_CHSEL: rd_word = 32'(s_q.sel_ch);
            OFF_PSEL:  rd_word = 32'(s_q.sel_port);
            OFF_GIEN:  rd_word = 32'(s_q.gien);
            OFF_PCTRL: if (pt_ok) rd_word = 32'(s_q.pctrl[pt_idx]);
            default: begin
                if (ch_ok) begin
                    case (win)
                        WIN_CTRL: rd_word = s_ctrl[ch_idx];
                        WIN_BASE: rd_word = s_base[ch_idx];
                        WIN_CNT:  rd_word = 32'(s_cnt[ch_idx]);
                        WIN_STAT: rd_word = 32'({s_stat[ch_idx], 1'b0});
                        WIN_IEN:  rd_word = 32'({s_ien[ch_idx], 1'b0});
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (bus_wr) begin
            case (bus_addr)
                OFF_CHSEL: s_d.sel_ch   = bus_wdata[SEL_W-1:0];
                OFF_PSEL:  s_d.sel_port = bus_wdata[SEL_W-1:0];
                OFF_POLL: begin
                    s_d.poll_en   = bus_wdata[POLL_EN];
                    s_d.poll_div4 = bus_wdata[POLL_DIV4];
                end
                OFF_GIEN:  s_d.gien = bus_wdata[NUM_CH-1:0];
                OFF_PCTRL: if (pt_ok) s_d.pctrl[pt_idx] = bus_wdata[PCTRL_W-1:0];
                default: ;
            endcase
        end
        s_d.rdata = bus_rd ? rd_word : s_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata    = s_q.rdata;
    assign engine_rst_o = eng_busy;
    assign irq_o        = |slot_irq;

    assert_gien_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gien == '0) |-> !irq_o);
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    assert_oob_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ch_ok && rst_busy == '0) |=> $stable(chan_on_o));
    assert_eng_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !eng_done) |=> engine_rst_o);
endmodule

// File: tb/dmac_reg_bank_tb_top.sv
module dmac_reg_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 20;
    localparam int SW  = 6;

    localparam logic [7:0] A_ID = 8'h08, A_GCTRL = 8'h10, A_POLL = 8'h14, A_CHSEL = 8'h18,
        A_CCTRL = 8'h1C, A_DBASE = 8'h20, A_DCNT = 8'h24, A_ISTAT = 8'h28, A_IEN = 8'h2C,
        A_PSEL = 8'h40, A_PCTRL = 8'h44, A_GIEN = 8'hF4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [31:0] rdata;
    logic [NCH*SW-1:0] evt = '0;
    logic [NCH-1:0] chan_on;
    logic engine_rst, irq;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic rd_seen = 1'b0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
        .bus_rd(rd), .bus_rdata(rdata), .evt_i(evt), .chan_on_o(chan_on),
        .engine_rst_o(engine_rst), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: read data is due one edge after the strobe
    always @(posedge clk) rd_seen <= rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk(rdata, 32'hx, "R12 unexpected read");
            else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr_t(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_t(input logic [7:0] a, input logic [31:0] e, input string tag);
        addr = a; rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse(input int c, input int k);
        evt[c*SW+k] = 1'b1;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD*50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state and identity word
        chk(32'(irq), 32'h0, "reset irq");
        chk(32'(chan_on), 32'h0, "reset chan_on");
        rd_t(A_ID, {12'd20, 4'd4, 11'b0, 5'h0A}, "R1 id");
        rd_t(A_CCTRL, 32'h0, "reset ctrl");
        rd_t(A_GIEN, 32'h0, "reset gien");
        wr_t(A_ID, 32'hFFFF_FFFF);
        rd_t(A_ID, {12'd20, 4'd4, 11'b0, 5'h0A}, "R1 id write ignored");

        // R2 banking
        wr_t(A_CHSEL, 3);  wr_t(A_DBASE, 32'hA5A5_0000); wr_t(A_DCNT, 32'h40);
        wr_t(A_CHSEL, 19); wr_t(A_DBASE, 32'h1234_5678); wr_t(A_DCNT, 32'h1FFFF);
        rd_t(A_CHSEL, 19, "R2 sel readback");
        rd_t(A_DBASE, 32'h1234_5678, "R2 base ch19");
        rd_t(A_DCNT, 32'hFFFF, "R2 cnt ch19 width");
        wr_t(A_CHSEL, 3);
        rd_t(A_DBASE, 32'hA5A5_0000, "R2 base ch3");
        rd_t(A_DCNT, 32'h40, "R2 cnt ch3");

        // R11 channel select out of range
        wr_t(A_CHSEL, 25); wr_t(A_DBASE, 32'hDEAD); wr_t(A_CCTRL, 1);
        rd_t(A_DBASE, 32'h0, "R11 oob base");
        rd_t(A_CHSEL, 25, "R11 sel readback");
        chk(32'(chan_on), 32'h0, "R11 oob ctrl ignored");
        wr_t(A_CHSEL, 3);
        rd_t(A_DBASE, 32'hA5A5_0000, "R11 ch3 untouched");

        // R3 control fields
        wr_t(A_CCTRL, 32'hFFFF_FFFD);
        rd_t(A_CCTRL, 32'h0003_0101, "R3 ctrl fields");
        chk(32'(chan_on), 32'h8, "R3 chan_on ch3");

        // R4 channel reset
        pulse(3, 2);
        rd_t(A_ISTAT, 32'h8, "R5 status before reset");
        wr_t(A_CCTRL, 32'h0000_0103);
        for (int i = 0; i < 4; i++) rd_t(A_CCTRL, 32'h103, "R4 busy");
        rd_t(A_CCTRL, 32'h100, "R4 done");
        rd_t(A_ISTAT, 32'h0, "R4 status cleared");
        chk(32'(chan_on), 32'h0, "R4 on cleared");

        // R5 / R6 status and enables
        wr_t(A_CHSEL, 5);
        pulse(5, 2);
        rd_t(A_ISTAT, 32'h8, "R5 event sets bit3");
        chk(32'(irq), 32'h0, "R6 irq masked by enable");
        wr_t(A_IEN, 32'h08);
        rd_t(A_IEN, 32'h08, "R6 enable readback");
        chk(32'(irq), 32'h0, "R7 irq masked by gien");
        wr_t(A_GIEN, 32'h20);
        chk(32'(irq), 32'h1, "R6 irq asserted");
        wr_t(A_ISTAT, 32'h02);
        rd_t(A_ISTAT, 32'h8, "R5 partial w1c");
        chk(32'(irq), 32'h1, "R6 irq kept");
        wr_t(A_ISTAT, 32'h7E);
        rd_t(A_ISTAT, 32'h0, "R5 ack all");
        chk(32'(irq), 32'h0, "R6 irq dropped");
        addr = A_ISTAT; wdata = 32'h7E; wr = 1'b1; evt[5*SW+2] = 1'b1;
        @(negedge clk);
        wr = 1'b0; evt = '0;
        rd_t(A_ISTAT, 32'h8, "R5 set wins over clear");
        pulse(5, 0);
        rd_t(A_ISTAT, 32'hA, "R5 second cause");

        // R7 global enable
        wr_t(A_GIEN, 32'h0);
        chk(32'(irq), 32'h0, "R7 gien zero");
        rd_t(A_GIEN, 32'h0, "R7 gien readback");
        wr_t(A_GIEN, 32'h10);
        chk(32'(irq), 32'h0, "R7 other channel enable");
        wr_t(A_GIEN, 32'h20);
        chk(32'(irq), 32'h1, "R7 own channel enable");

        // R8 engine reset
        wr_t(A_GCTRL, 32'h1);
        chk(32'(engine_rst), 32'h1, "R8 engine_rst high");
        for (int i = 0; i < 4; i++) rd_t(A_GCTRL, 32'h1, "R8 busy");
        rd_t(A_GCTRL, 32'h0, "R8 done");
        chk(32'(engine_rst), 32'h0, "R8 engine_rst low");

        // R9 polling
        wr_t(A_POLL, 32'hFFFF_FFFF);
        rd_t(A_POLL, 32'h8000_0040, "R9 poll bits");
        wr_t(A_POLL, 32'h7FFF_FFBF);
        rd_t(A_POLL, 32'h0, "R9 other bits dropped");

        // R10 / R11 ports
        wr_t(A_PSEL, 1); wr_t(A_PCTRL, 32'hFFFF);
        wr_t(A_PSEL, 3); wr_t(A_PCTRL, 32'h0F40);
        wr_t(A_PSEL, 1);
        rd_t(A_PCTRL, 32'hFFF, "R10 port1");
        rd_t(A_PSEL, 1, "R10 psel readback");
        wr_t(A_PSEL, 3);
        rd_t(A_PCTRL, 32'hF40, "R10 port3");
        wr_t(A_PSEL, 9); wr_t(A_PCTRL, 32'h123);
        rd_t(A_PCTRL, 32'h0, "R11 oob port");
        wr_t(A_PSEL, 0);
        rd_t(A_PCTRL, 32'h0, "R11 port0 untouched");

        // last channel on
        wr_t(A_CHSEL, 19); wr_t(A_CCTRL, 32'h1);
        chk(32'(chan_on), 32'h8_0000, "R3 chan_on ch19");

        // R12 unmapped and hold
        rd_t(8'h30, 32'h0, "R12 unmapped");
        wr_t(A_CHSEL, 3);
        rd_t(A_DBASE, 32'hA5A5_0000, "R12 read");
        repeat (2) @(negedge clk);
        chk(rdata, 32'hA5A5_0000, "R12 rdata holds");

        chk(32'(exp_q.size()), 32'h0, "R12 queue drained");
        finish_run();
    end
endmodule